// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs single read and write accesses to an external data memory over an 8-bit bus that carries the low address byte first and then the data. At the start of an access the block raises an address latch strobe. An external register captures the low address from the shared bus on the falling edge of that strobe. The bus is then free for data. A separate 8-bit port gives the high address byte in linear mode. In paged mode that port instead passes through a page value that software supplies.

Requests come in on a valid/ready port. `req_ready` is high only while the controller is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. While an access is running, `req_ready` stays low and the requester must hold its request or withdraw it. The response is a one-cycle `rsp_valid` pulse with `rsp_rdata`. The response cannot be stalled, so the consumer must take it in that cycle.

A 2-bit wait setting stretches the read or write strobe. A control input selects how the latch strobe behaves while no access is running: it either free-runs or holds high.

Top module: `xmb_ctrl`

## Requirements
- R1: During and right after reset, `rd_n` and `wr_n` are 1, `bus_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only in the idle state. From the cycle after acceptance until the done cycle, `req_ready` is 0. A `req_valid` held high during that time starts no second access.
- R3: The first cycle after acceptance is the address cycle: `ale`=1, `bus_oe`=1, `bus_out`=address bits [7:0]. The next cycle is the latch cycle: `ale`=0 with `bus_out` and `hi_addr` unchanged. The address is therefore stable across the falling edge of `ale`.
- R4: With `req_paged`=0 (linear mode), `hi_addr` equals address bits [15:8] from the address cycle through the recovery cycle. At all other times, and always with `req_paged`=1, `hi_addr` equals `page_reg`.
- R5: The strobe goes low in the cycle after the latch cycle and stays low for 1 + `wait_cfg` cycles. The strobe is `wr_n` when `req_write`=1 and `rd_n` when `req_write`=0. The two strobes are never low together.
- R6: During a write, `bus_oe`=1 and `bus_out`=`req_wdata` for every cycle that `wr_n` is low, and for the recovery cycle after it.
- R7: During a read, `bus_oe`=0 from the first strobe cycle on. `rsp_rdata` equals the value of `bus_in` in the last cycle that `rd_n` is low.
- R8: `rsp_valid` is a one-cycle pulse in the cycle after the recovery cycle. The recovery cycle is the first cycle with the strobe high again. `req_ready` returns to 1 in the following cycle.
- R9: Outside the address, latch, strobe and recovery cycles, `ale` inverts every cycle when `ale_idle_off`=0, and is held at 1 when `ale_idle_off`=1.
- R10: Address, mode, direction, write data and wait count are captured at acceptance. Changing those inputs during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Access address |
| req_paged | input | 1 | 1 = paged mode, 0 = linear mode |
| req_wdata | input | 8 | Write data |
| wait_cfg | input | 2 | Extra strobe cycles (0 to 3) |
| ale_idle_off | input | 1 | 1 = hold `ale` high while idle |
| page_reg | input | 8 | Software page value for the high port |
| rsp_valid | output | 1 | Access done pulse |
| rsp_rdata | output | 8 | Read data |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| hi_addr | output | 8 | High address or page byte |
| bus_out | output | 8 | Shared bus output value |
| bus_oe | output | 1 | Shared bus output enable |
| bus_in | input | 8 | Shared bus input value |

## Verification
The assertions assume that `ale_idle_off` changes only while the controller is idle. They do not assume that `page_reg` is steady, so the address-stability property is applied only to the falling edge of `ale` inside an access. The bench changes `ale_idle_off` and `page_reg` only between accesses. In the middle of each access it deliberately inverts every request field to check that nothing leaks into the running access.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;
endpackage

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [WS_W-1:0] wait_cfg,
  output logic            req_ready,
  output logic            accept,
  output phase_e          phase,
  output logic            strobe_last,
  output logic            is_wr,
  output logic            rd_n,
  output logic            wr_n,
  output logic            rsp_valid
);
  localparam int RUN_W = WS_W + 2;

  phase_e          phase_q, phase_d;
  logic [WS_W-1:0] ws_q;
  logic [WS_W-1:0] cnt_q;
  logic            wr_q;

  assign req_ready   = (phase_q == PH_IDLE);
  assign accept      = req_ready && req_valid;
  assign phase       = phase_q;
  assign is_wr       = wr_q;
  assign strobe_last = (phase_q == PH_STRB) && (cnt_q == '0);
  assign rd_n        = !((phase_q == PH_STRB) && !wr_q);
  assign wr_n        = !((phase_q == PH_STRB) && wr_q);
  assign rsp_valid   = (phase_q == PH_DONE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (accept) phase_d = PH_ADDR;
      PH_ADDR:  phase_d = PH_LATCH;
      PH_LATCH: phase_d = PH_STRB;
      PH_STRB:  if (cnt_q == '0) phase_d = PH_HOLD;
      PH_HOLD:  phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ws_q    <= '0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        ws_q <= wait_cfg;
        wr_q <= req_write;
      end
      if (phase_q == PH_LATCH) cnt_q <= ws_q;
      else if (phase_q == PH_STRB && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // Checker: length of each strobe-low run
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!rd_n || !wr_n) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> (low_run == RUN_W'(ws_q) + 1'b1));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_valid) |=> !req_ready);
endmodule

// File: rtl/xmb_ale_gen.sv
module xmb_ale_gen
  import xmb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   ale_idle_off,
  output logic   ale
);
  logic tog_q;
  logic in_access;

  assign in_access = (phase == PH_ADDR) || (phase == PH_LATCH) ||
                     (phase == PH_STRB) || (phase == PH_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) tog_q <= 1'b1;
    else        tog_q <= !tog_q;
  end

  always_comb begin
    if (in_access)         ale = (phase == PH_ADDR);
    else if (ale_idle_off) ale = 1'b1;
    else                   ale = tog_q;
  end

  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_idle_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !in_access && !ale_idle_off && $past(!in_access && !ale_idle_off))
      |-> (ale != $past(ale)));

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_access && ale_idle_off) |-> ale);
endmodule

// File: rtl/xmb_datapath.sv
module xmb_datapath
  import xmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic          req_paged,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-DW-1:0] page_reg,
  input  logic [DW-1:0] bus_in,
  input  phase_e        phase,
  input  logic          strobe_last,
  input  logic          is_wr,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [AW-DW-1:0] hi_addr,
  output logic [DW-1:0] rsp_rdata
);
  localparam int HW = AW - DW;

  logic [AW-1:0] addr_q;
  logic          paged_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          addr_ph, data_ph, in_access;

  assign addr_ph   = (phase == PH_ADDR) || (phase == PH_LATCH);
  assign data_ph   = (phase == PH_STRB) || (phase == PH_HOLD);
  assign in_access = addr_ph || data_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      paged_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        paged_q <= req_paged;
        wdata_q <= req_wdata;
      end
      if (strobe_last && !is_wr) rdata_q <= bus_in;
    end
  end

  always_comb begin
    bus_out = '0;
    bus_oe  = 1'b0;
    if (addr_ph) begin
      bus_out = addr_q[DW-1:0];
      bus_oe  = 1'b1;
    end else if (data_ph && is_wr) begin
      bus_out = wdata_q;
      bus_oe  = 1'b1;
    end
  end

  assign hi_addr   = (in_access && !paged_q) ? addr_q[AW-1:DW] : page_reg;
  assign rsp_rdata = rdata_q;

  assert_read_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && !is_wr) |-> !bus_oe);

  assert_hi_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_access) |-> (hi_addr == HW'(page_reg)));
endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
  import xmb_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int WS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_paged,
  input  logic [DW-1:0]    req_wdata,
  input  logic [WS_W-1:0]  wait_cfg,
  input  logic             ale_idle_off,
  input  logic [AW-DW-1:0] page_reg,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [AW-DW-1:0] hi_addr,
  output logic [DW-1:0]    bus_out,
  output logic             bus_oe,
  input  logic [DW-1:0]    bus_in
);
  phase_e phase;
  logic   accept, strobe_last, is_wr;

  xmb_seq #(.WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .wait_cfg(wait_cfg), .req_ready(req_ready), .accept(accept), .phase(phase),
    .strobe_last(strobe_last), .is_wr(is_wr), .rd_n(rd_n), .wr_n(wr_n),
    .rsp_valid(rsp_valid)
  );

  xmb_ale_gen u_ale (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ale_idle_off(ale_idle_off), .ale(ale)
  );

  xmb_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_paged(req_paged), .req_wdata(req_wdata), .page_reg(page_reg),
    .bus_in(bus_in), .phase(phase), .strobe_last(strobe_last), .is_wr(is_wr),
    .bus_out(bus_out), .bus_oe(bus_oe), .hi_addr(hi_addr), .rsp_rdata(rsp_rdata)
  );

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && !req_ready && !rsp_valid)
      |-> (bus_oe && $stable(bus_out) && $stable(hi_addr)));

  assert_read_strobe_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n) |-> !bus_oe);

  assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (bus_oe && $stable(bus_out)));

  assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n) |-> bus_oe);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !bus_oe));
endmodule

// File: tb/xmb_ctrl_tb.sv
module xmb_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_paged = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, page_reg = '0, bus_in = '0;
  logic [1:0]  wait_cfg = '0;
  logic        ale_idle_off = 1'b0;
  logic        req_ready, rsp_valid, ale, rd_n, wr_n, bus_oe;
  logic [7:0]  rsp_rdata, hi_addr, bus_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic last_ale;
  bit   last_ok = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmb_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_paged(req_paged),
    .req_wdata(req_wdata), .wait_cfg(wait_cfg), .ale_idle_off(ale_idle_off),
    .page_reg(page_reg), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .hi_addr(hi_addr),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_hi(input bit pg, input logic [15:0] a,
                                        input bit active, input logic [7:0] pr);
    return (active && !pg) ? a[15:8] : pr;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 ready idle", req_ready, 1);
      chk("R2 no access rd_n", rd_n, 1);
      chk("R2 no access wr_n", wr_n, 1);
      chk("R2 bus released", bus_oe, 0);
      chk("R8 no done idle", rsp_valid, 0);
      chk("R4 idle hi", hi_addr, page_reg);
      if (ale_idle_off) chk("R9 ale held", ale, 1);
      else if (last_ok) chk("R9 ale toggles", ale, !last_ale);
      last_ale = ale;
      last_ok  = !ale_idle_off;
    end
  endtask

  task automatic xfer(input bit w, input logic [15:0] a, input bit pg,
                      input int ws, input logic [7:0] wd, input bit poke);
    logic [7:0] exp_rd;
    int last;
    exp_rd = '0;
    last = 4 + ws;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_paged = pg;
    wait_cfg = ws[1:0]; req_wdata = wd;
    chk("R2 ready before", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // R10: disturb every request field during the access
    req_valid = poke; req_write = !w; req_addr = ~a; req_paged = !pg;
    wait_cfg = ~ws[1:0]; req_wdata = ~wd;
    for (int p = 0; p <= last; p++) begin
      if (p > 0) @(negedge clk);
      chk("R4 hi_addr", hi_addr, exp_hi(pg, a, p <= 3 + ws, page_reg));
      if (p < last) begin
        chk("R2 busy not ready", req_ready, 0);
        chk("R8 no early done", rsp_valid, 0);
      end
      if (p == 0) begin
        chk("R3 ale high", ale, 1);
        chk("R3 oe addr", bus_oe, 1);
        chk("R3 bus addr", bus_out, a[7:0]);
        chk("R5 strobes high addr", {rd_n, wr_n}, 3);
      end else if (p == 1) begin
        chk("R3 ale low latch", ale, 0);
        chk("R3 oe latch", bus_oe, 1);
        chk("R3 bus stable", bus_out, a[7:0]);
        chk("R5 strobes high latch", {rd_n, wr_n}, 3);
      end else if (p <= 2 + ws) begin
        chk("R5 rd_n", rd_n, w);
        chk("R5 wr_n", wr_n, !w);
        chk("R3 ale low strobe", ale, 0);
        if (w) begin
          chk("R6 oe write", bus_oe, 1);
          chk("R6 wdata", bus_out, wd);
        end else begin
          chk("R7 oe read", bus_oe, 0);
          bus_in = 8'($urandom);
          if (p == 2 + ws) exp_rd = bus_in;
        end
      end else if (p == 3 + ws) begin
        chk("R5 strobes released", {rd_n, wr_n}, 3);
        chk("R3 ale low hold", ale, 0);
        if (w) begin
          chk("R6 oe hold", bus_oe, 1);
          chk("R6 wdata hold", bus_out, wd);
        end else begin
          chk("R7 oe hold", bus_oe, 0);
          bus_in = 8'($urandom);
        end
      end else begin
        chk("R8 done pulse", rsp_valid, 1);
        chk("R8 not ready in done", req_ready, 0);
        chk("R5 strobes high done", {rd_n, wr_n}, 3);
        if (!w) chk("R7 read data", rsp_rdata, exp_rd);
        if (ale_idle_off) chk("R9 ale held done", ale, 1);
        req_valid = 0;
        last_ale = ale;
        last_ok  = !ale_idle_off;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    chk("R1 rd_n reset", rd_n, 1);
    chk("R1 wr_n reset", wr_n, 1);
    chk("R1 oe reset", bus_oe, 0);
    chk("R1 ready reset", req_ready, 1);
    chk("R1 done reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_n after", rd_n, 1);
    chk("R1 wr_n after", wr_n, 1);
    last_ok = 0;
    idle_cycles(4);

    // Directed corners
    page_reg = 8'h5a;
    xfer(1, 16'hbeef, 0, 0, 8'h11, 0); idle_cycles(2);
    xfer(0, 16'h1234, 0, 3, 8'h00, 0); idle_cycles(2);
    xfer(1, 16'hc0de, 1, 3, 8'hee, 1); idle_cycles(2);
    xfer(0, 16'h00ff, 1, 0, 8'h00, 1); idle_cycles(1);
    ale_idle_off = 1;
    idle_cycles(3);
    xfer(0, 16'hffff, 0, 2, 8'h00, 0); idle_cycles(3);
    ale_idle_off = 0;
    idle_cycles(3);

    // Constrained random
    for (int n = 0; n < 200; n++) begin
      page_reg     = 8'($urandom);
      ale_idle_off = 1'($urandom % 4 == 0);
      xfer(1'($urandom), 16'($urandom), 1'($urandom), int'($urandom % 4),
           8'($urandom), 1'($urandom % 3 == 0));
      idle_cycles(1 + int'($urandom % 4));
    end
    finish_run();
  end
endmodule